// File: doc/BRIEF.md
# Sticky Limit-Status Interrupt Controller

This block gathers the out-of-limit results of a hardware monitor's measurement channels into two 8-bit status registers and drives an active-low alert line to a system supervisor. Each channel presents a fault flag together with an update strobe. The strobe is pulsed once for every new measurement. A fault latches the channel's status bit, and the bit then stays latched after the measurement returns within limits. Software can clear the bit only by reading its register, and only after the last measurement of that channel came back in limits.

The first status register carries a live summary bit. The bit is set whenever any bit of the second register is set, so a poller can skip the second read when the summary is clear. Two mask registers suppress individual sources from the alert line. A masked fault is still recorded in its status bit. The alert line is low for as long as any unmasked status bit is set. It therefore covers the whole time a reading is out of limits, and the time after that until the clearing read.

Reads are combinational. Read data is valid in the same cycle as the read strobe and shows the state before any clear. A clear caused by the read takes effect at the following clock edge.

Top module: `lim_alert_ctrl`

## Requirements
- R1: After reset, all status bits and both mask registers are 0, `alert_n_o` is 1, and reads of 0x41, 0x42, 0x74 and 0x75 return 0.
- R2: An update strobe with the fault flag at 1 sets that channel's status bit at the next clock edge. The valid channel bits are 6, 5, 4, 2 and 1 of the first register (read at 0x41) and bits 7 to 1 of the second register (read at 0x42).
- R3: An update with the fault flag at 0 does not clear a status bit that is already set.
- R4: A read of a status register leaves set every bit whose latest update reported a fault.
- R5: A read of a status register clears, at the next edge, every set bit whose latest update was in limits.
- R6: Bit 7 of the read data at 0x41 is 1 exactly when any of bits 7 to 1 of the second register is set. The bit is recomputed on every read and is never latched on its own.
- R7: Bits 0 and 3 at 0x41 and bit 0 at 0x42 always read 0. Updates on those positions have no effect on the read data or on the alert.
- R8: A write to 0x74 loads the mask of the first register, and a write to 0x75 loads the mask of the second register. Each value reads back at its own address. A mask bit of 1 suppresses the alert for that position.
- R9: A masked source still sets its status bit on a fault, but by itself it does not drive `alert_n_o` low.
- R10: `alert_n_o` is 0 exactly when some status bit is set whose mask bit is 0. It returns to 1 in the cycle after the clearing read of the last such bit.
- R11: When a fault update and a clearing read of the same bit fall in the same cycle, the bit stays set.
- R12: A read with the read strobe low, or at any other address, returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st1_flag_i | input | 8 | Fault flags of the channels in the first register |
| st1_upd_i | input | 8 | Update strobes of the channels in the first register |
| st2_flag_i | input | 8 | Fault flags of the channels in the second register |
| st2_upd_i | input | 8 | Update strobes of the channels in the second register |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Read data, valid in the same cycle as the read strobe |
| wr_en_i | input | 1 | Mask write strobe |
| wr_addr_i | input | 8 | Mask write address |
| wr_data_i | input | 8 | Mask write data |
| alert_n_o | output | 1 | Active-low alert |

## Verification
The directed patterns cover four sequences on the same bit:
- a fault followed by reads while the fault is still present, which tells the clear-on-read rule apart from a plain clear-on-read register;
- an in-limit update followed by two reads, which shows that the release happens on the read and not on the update;
- a masked fault, which separates the alert gating from the status recording;
- a fault update that lands in the same cycle as a clearing read, which decides set-over-clear priority.

Further patterns check the following:
- Second-register faults are read through the first register, which shows that the summary is live rather than latched.
- Strobes on unused positions and reads at stray addresses show that they have no effect.
- A long random run mixes updates, reads and mask writes, so that per-bit independence is exercised across both registers.

// File: rtl/lim_alert_pkg.sv
package lim_alert_pkg;

    localparam int LIM_REG_W  = 8;
    localparam int LIM_ADDR_W = 8;
    localparam int LIM_NBANK  = 2;

    localparam logic [LIM_ADDR_W-1:0] LIM_STAT_BASE = 8'h41;
    localparam logic [LIM_ADDR_W-1:0] LIM_MASK_BASE = 8'h74;

    // address of status register g
    function automatic logic [LIM_ADDR_W-1:0] bank_addr(int g);
        return LIM_STAT_BASE + LIM_ADDR_W'(g);
    endfunction

    // address of mask register g
    function automatic logic [LIM_ADDR_W-1:0] mask_addr(int g);
        return LIM_MASK_BASE + LIM_ADDR_W'(g);
    endfunction

    // channel positions implemented in status register g
    function automatic logic [LIM_REG_W-1:0] bank_valid(int g);
        return (g == 0) ? 8'b0111_0110 : 8'b1111_1110;
    endfunction

endpackage

// File: rtl/lim_status_bank.sv
module lim_status_bank
    import lim_alert_pkg::*;
#(
    parameter int                W     = LIM_REG_W,
    parameter logic [W-1:0]      VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flag_i,
    input  logic [W-1:0] upd_i,
    input  logic         clr_rd_i,
    output logic [W-1:0] sticky_o,
    output logic [W-1:0] live_o
);

    typedef struct packed {
        logic [W-1:0] sticky;
        logic [W-1:0] live;
    } bank_t;

    bank_t        st_d, st_q;
    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;

    always_comb begin
        set_vec = upd_i & flag_i & VALID;
        clr_vec = '0;
        if (clr_rd_i) begin
            clr_vec = VALID & ~st_q.live & ~set_vec;
        end
        st_d        = st_q;
        st_d.sticky = (st_q.sticky & ~clr_vec) | set_vec;
        st_d.live   = ((st_q.live & ~upd_i) | (upd_i & flag_i)) & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sticky_o = st_q.sticky;
    assign live_o   = st_q.live;

    // R2 and R11: a fault update is recorded at the next edge, whatever the read does
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((sticky_o & $past(set_vec)) == $past(set_vec)));

    // R4 and R3: a bit whose channel is still faulty never drops
    p_hold_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(sticky_o & live_o) & ~sticky_o) == '0));

    // R5: a bit can only fall in the cycle after a clearing read
    p_clear_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(sticky_o) & ~sticky_o) != '0) -> $past(clr_rd_i)));

endmodule

// File: rtl/lim_mask_regs.sv
module lim_mask_regs
    import lim_alert_pkg::*;
#(
    parameter int NBANK  = LIM_NBANK,
    parameter int REG_W  = LIM_REG_W,
    parameter int ADDR_W = LIM_ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [ADDR_W-1:0]           wr_addr_i,
    input  logic [REG_W-1:0]            wr_data_i,
    output logic [NBANK-1:0][REG_W-1:0] mask_o
);

    typedef struct packed {
        logic [NBANK-1:0][REG_W-1:0] mask;
    } mask_t;

    mask_t            mk_d, mk_q;
    logic [NBANK-1:0] wr_hit;

    for (genvar g = 0; g < NBANK; g++) begin : g_dec
        assign wr_hit[g] = wr_en_i && (wr_addr_i == ADDR_W'(mask_addr(g)));
    end

    always_comb begin
        mk_d = mk_q;
        for (int g = 0; g < NBANK; g++) begin
            if (wr_hit[g]) begin
                mk_d.mask[g] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mk_q <= '0;
        end else begin
            mk_q <= mk_d;
        end
    end

    assign mask_o = mk_q.mask;

    // R8: without a write strobe the masks keep their value
    p_mask_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(mask_o));

endmodule

// File: rtl/lim_read_mux.sv
module lim_read_mux
    import lim_alert_pkg::*;
#(
    parameter int NBANK  = LIM_NBANK,
    parameter int REG_W  = LIM_REG_W,
    parameter int ADDR_W = LIM_ADDR_W
) (
    input  logic                        rd_en_i,
    input  logic [ADDR_W-1:0]           rd_addr_i,
    input  logic [NBANK-1:0][REG_W-1:0] sticky_i,
    input  logic [NBANK-1:0][REG_W-1:0] mask_i,
    output logic [REG_W-1:0]            rd_data_o,
    output logic [NBANK-1:0]            rd_hit_o
);

    logic summary;

    assign summary = |sticky_i[NBANK-1][REG_W-1:1];

    always_comb begin
        rd_data_o = '0;
        rd_hit_o  = '0;
        if (rd_en_i) begin
            for (int g = 0; g < NBANK; g++) begin
                if (rd_addr_i == ADDR_W'(bank_addr(g))) begin
                    rd_data_o   = sticky_i[g];
                    rd_hit_o[g] = 1'b1;
                end
                if (rd_addr_i == ADDR_W'(mask_addr(g))) begin
                    rd_data_o = mask_i[g];
                end
            end
            if (rd_hit_o[0]) begin
                rd_data_o[REG_W-1] = summary;
            end
        end
    end

    // R12: at most one register is selected per read
    p_one_hit_r12: assert final ($onehot0(rd_hit_o));

endmodule

// File: rtl/lim_alert_ctrl.sv
module lim_alert_ctrl
    import lim_alert_pkg::*;
#(
    parameter int REG_W  = LIM_REG_W,
    parameter int ADDR_W = LIM_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  st1_flag_i,
    input  logic [REG_W-1:0]  st1_upd_i,
    input  logic [REG_W-1:0]  st2_flag_i,
    input  logic [REG_W-1:0]  st2_upd_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [REG_W-1:0]  rd_data_o,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic              alert_n_o
);

    localparam int NBANK = LIM_NBANK;

    logic [NBANK-1:0][REG_W-1:0] flag_a, upd_a, sticky_a, live_a, mask_a;
    logic [NBANK-1:0]            hit_a;
    logic [NBANK-1:0]            src_a;

    assign flag_a = {st2_flag_i, st1_flag_i};
    assign upd_a  = {st2_upd_i, st1_upd_i};

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        lim_status_bank #(
            .W     (REG_W),
            .VALID (REG_W'(bank_valid(g)))
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .flag_i   (flag_a[g]),
            .upd_i    (upd_a[g]),
            .clr_rd_i (hit_a[g]),
            .sticky_o (sticky_a[g]),
            .live_o   (live_a[g])
        );
        assign src_a[g] = |(sticky_a[g] & ~mask_a[g]);
    end

    lim_mask_regs #(
        .NBANK  (NBANK),
        .REG_W  (REG_W),
        .ADDR_W (ADDR_W)
    ) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .mask_o    (mask_a)
    );

    lim_read_mux #(
        .NBANK  (NBANK),
        .REG_W  (REG_W),
        .ADDR_W (ADDR_W)
    ) u_rmux (
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .sticky_i  (sticky_a),
        .mask_i    (mask_a),
        .rd_data_o (rd_data_o),
        .rd_hit_o  (hit_a)
    );

    assign alert_n_o = ~(|src_a);

    // R9: with every source masked the alert stays released
    p_all_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_a) |-> alert_n_o);

    // R6: a summary bit seen at 0x41 implies a set bit in the second register
    p_summary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i == ADDR_W'(bank_addr(0)) && rd_data_o[REG_W-1])
            |-> (sticky_a[NBANK-1] != '0));

    // R10: an asserted alert implies some recorded fault
    p_alert_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_n_o |-> ((sticky_a[0] | sticky_a[1]) != '0));

    // R7: unused positions of the first register stay clear
    p_unused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sticky_a[0] & ~REG_W'(bank_valid(0))) == '0));

    logic unused_live;
    assign unused_live = ^live_a;

endmodule

// File: tb/lim_alert_ctrl_tb.sv
module lim_alert_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] f1 = '0, u1 = '0, f2 = '0, u2 = '0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] ra = '0, wa = '0, wd = '0;
    logic [7:0] rdata;
    logic       alert_n;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference state
    bit [7:0] m_stk[2];
    bit [7:0] m_live[2];
    bit [7:0] m_mask[2];
    bit [7:0] vmask[2];

    always #2 clk = ~clk;

    lim_alert_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .st1_flag_i (f1),
        .st1_upd_i  (u1),
        .st2_flag_i (f2),
        .st2_upd_i  (u2),
        .rd_en_i    (rd),
        .rd_addr_i  (ra),
        .rd_data_o  (rdata),
        .wr_en_i    (wr),
        .wr_addr_i  (wa),
        .wr_data_i  (wd),
        .alert_n_o  (alert_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] exp_read();
        bit [7:0] v = 8'h00;
        if (rd) begin
            case (ra)
                8'h41: begin
                    v = m_stk[0];
                    v[7] = (m_stk[1] & 8'hFE) != 0;
                end
                8'h42: v = m_stk[1];
                8'h74: v = m_mask[0];
                8'h75: v = m_mask[1];
                default: v = 8'h00;
            endcase
        end
        return v;
    endfunction

    function automatic bit exp_alert_n();
        bit any = 0;
        for (int g = 0; g < 2; g++) begin
            for (int b = 0; b < 8; b++) begin
                if (m_stk[g][b] && !m_mask[g][b]) any = 1;
            end
        end
        return !any;
    endfunction

    // one cycle: inputs already set at negedge; compare, then advance model
    task automatic cyc(input string tag);
        bit [7:0] ff[2];
        bit [7:0] uu[2];
        #1;
        check(rdata == exp_read(), tag, rdata, exp_read());
        check(alert_n == exp_alert_n(), {tag, "/R10 alert"}, alert_n, exp_alert_n());
        ff[0] = f1; ff[1] = f2; uu[0] = u1; uu[1] = u2;
        @(posedge clk);
        for (int g = 0; g < 2; g++) begin
            for (int b = 0; b < 8; b++) begin
                bit setb, clrb;
                setb = vmask[g][b] && uu[g][b] && ff[g][b];
                clrb = rd && (ra == 8'h41 + 8'(g)) && vmask[g][b] && !m_live[g][b];
                if (setb) m_stk[g][b] = 1;
                else if (clrb) m_stk[g][b] = 0;
                if (vmask[g][b] && uu[g][b]) m_live[g][b] = ff[g][b];
            end
            if (wr && wa == 8'h74 + 8'(g)) m_mask[g] = wd;
        end
        @(negedge clk);
        f1 = '0; u1 = '0; f2 = '0; u2 = '0;
        rd = 0; ra = '0; wr = 0; wa = '0; wd = '0;
    endtask

    task automatic idle(input string tag);
        cyc(tag);
    endtask

    task automatic meas(input int g, input bit [7:0] bits, input bit flt, input string tag);
        if (g == 0) begin u1 = bits; f1 = flt ? bits : 8'h00; end
        else        begin u2 = bits; f2 = flt ? bits : 8'h00; end
        cyc(tag);
    endtask

    task automatic rdreg(input bit [7:0] a, input string tag);
        rd = 1; ra = a;
        cyc(tag);
    endtask

    task automatic wrmask(input bit [7:0] a, input bit [7:0] d, input string tag);
        wr = 1; wa = a; wd = d;
        cyc(tag);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        vmask[0] = 8'b0111_0110;
        vmask[1] = 8'b1111_1110;
        for (int g = 0; g < 2; g++) begin
            m_stk[g] = 0; m_live[g] = 0; m_mask[g] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rdreg(8'h41, "R1 st1");
        rdreg(8'h42, "R1 st2");
        rdreg(8'h74, "R1 m1");
        rdreg(8'h75, "R1 m2");

        // R2 set, R4 read during fault keeps it
        meas(0, 8'h20, 1, "R2 set local");
        rdreg(8'h41, "R4 read during fault");
        rdreg(8'h41, "R4 read again");
        // R3 in-limit update does not clear, R5 read afterwards clears
        meas(0, 8'h20, 0, "R3 in-limit update");
        idle("R3 still set");
        rdreg(8'h41, "R5 clearing read");
        rdreg(8'h41, "R5 cleared");
        idle("R10 released");

        // R6 summary is live
        meas(1, 8'h08, 1, "R2 fan2");
        rdreg(8'h41, "R6 summary set");
        rdreg(8'h42, "R6 st2 view");
        meas(1, 8'h08, 0, "R3 fan2 ok");
        rdreg(8'h42, "R5 clear st2");
        rdreg(8'h41, "R6 summary follows");

        // R7 unused positions
        meas(0, 8'h89, 1, "R7 unused st1");
        meas(1, 8'h01, 1, "R7 unused st2");
        rdreg(8'h41, "R7 read st1");
        rdreg(8'h42, "R7 read st2");

        // R8 mask write and readback, R9 masked fault
        wrmask(8'h74, 8'h02, "R8 write m1");
        rdreg(8'h74, "R8 readback m1");
        meas(0, 8'h02, 1, "R9 masked fault");
        rdreg(8'h41, "R9 status recorded");
        wrmask(8'h74, 8'h00, "R8 unmask");
        idle("R10 unmasked alert");
        meas(0, 8'h02, 0, "R3 vccp ok");
        rdreg(8'h41, "R10 clear vccp");
        idle("R10 after clear");

        // R11 set wins over clear
        meas(0, 8'h40, 1, "R2 remote2");
        meas(0, 8'h40, 0, "R3 remote2 ok");
        u1 = 8'h40; f1 = 8'h40; rd = 1; ra = 8'h41;
        cyc("R11 set with read");
        rdreg(8'h41, "R11 still set");

        // R12 stray reads and idle strobe
        meas(0, 8'h40, 0, "R3 remote2 ok again");
        rdreg(8'h43, "R12 stray addr");
        ra = 8'h41;
        cyc("R12 no strobe");
        rdreg(8'h41, "R12 bit survived");
        rdreg(8'h41, "R5 now cleared");

        // multi-bit pattern with full mask on the second register
        wrmask(8'h75, 8'hFF, "R8 write m2");
        meas(1, 8'hFE, 1, "R9 all st2 masked");
        rdreg(8'h41, "R6 summary under mask");
        meas(1, 8'hFE, 0, "R3 st2 ok");
        rdreg(8'h42, "R5 clear all st2");
        wrmask(8'h75, 8'h00, "R8 clear m2");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k < 4) begin
                u1 = 8'($urandom); f1 = 8'($urandom);
                u2 = 8'($urandom); f2 = 8'($urandom);
            end
            if (k >= 3 && k < 8) begin
                rd = 1;
                case ($urandom_range(0, 4))
                    0: ra = 8'h41;
                    1: ra = 8'h42;
                    2: ra = 8'h74;
                    3: ra = 8'h75;
                    default: ra = 8'($urandom);
                endcase
            end
            if (k == 9) begin
                wr = 1; wa = ($urandom_range(0, 1) == 0) ? 8'h74 : 8'h75;
                wd = 8'($urandom);
            end
            cyc("R2 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule